// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Write Link

This block carries write transactions from a master to a slave that run from unrelated clocks. The two sides share only a bundle of address, direction and data wires, plus a request line driven by the master and an acknowledge line driven by the slave. Neither side samples the other's control line directly. Each line first passes through a chain of synchronising flops in the receiving clock domain.

A local command port on the master side accepts one command at a time. On acceptance the master puts the address, direction and data onto the bundle. It then counts a programmable number of its own clock cycles so that slaves can decode the target, and only then raises request. The slave takes the bundle when it sees request, writes it to its storage and raises acknowledge. The master drops request once it sees acknowledge. The slave drops acknowledge once it sees request low. When the master sees acknowledge low again, it reports completion and becomes ready for the next command. Because every edge waits for the previous one, the link works for any ratio between the two clock rates.

Top module: `hs4_link`

## Requirements
- R1: While both resets are held low and after release, `cmd_ready` is 1 and `bus_req`, `bus_ack`, `wr_en` and `cmd_done` are 0.
- R2: A command is accepted at a master clock edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle, `bus_addr`, `bus_write` and `bus_data` carry that command with `bus_req` still 0. They stay unchanged until the handshake completes.
- R3: `bus_req` rises exactly SETTLE_CYC master cycles after the accepting edge. Values of SETTLE_CYC below 1 are treated as 1.
- R4: For a write, the slave pulses `wr_en` for exactly one slave cycle with `wr_addr`/`wr_data` equal to the bundle. It raises `bus_ack` at that same slave edge, never before.
- R5: The master lowers `bus_req` only after it has seen `bus_ack` high through its synchroniser.
- R6: The slave lowers `bus_ack` only after it has seen `bus_req` low through its synchroniser.
- R7: `cmd_ready` stays 0 while `bus_req` or `bus_ack` is high. After the master sees `bus_ack` low, it pulses `cmd_done` for one master cycle and raises `cmd_ready` again. Commands held back-to-back complete in issue order.
- R8: `cmd_write` = 1 means write. A command with `cmd_write` = 0 completes the full handshake but gives no `wr_en` pulse and leaves `wr_addr` and `wr_data` unchanged.
- R9: Each control line crosses through SYNC_STAGES (at least 2) flops of the receiving clock. Transfers stay correct whether the slave clock is faster or much slower than the master clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | Master-side clock |
| m_rst_n | input | 1 | Master synchronous active-low reset |
| cmd_valid | input | 1 | Command present on the local port |
| cmd_write | input | 1 | 1 = write, 0 = non-write transaction |
| cmd_addr | input | ADDR_W | Command address |
| cmd_data | input | DATA_W | Command write data |
| cmd_ready | output | 1 | Master idle and able to accept |
| cmd_done | output | 1 | One-cycle pulse when a transaction completes |
| s_clk | input | 1 | Slave-side clock |
| s_rst_n | input | 1 | Slave synchronous active-low reset |
| wr_en | output | 1 | Slave storage write strobe |
| wr_addr | output | ADDR_W | Slave storage write address |
| wr_data | output | DATA_W | Slave storage write data |
| bus_req | output | 1 | Request line, master to slave |
| bus_ack | output | 1 | Acknowledge line, slave to master |
| bus_addr | output | ADDR_W | Address on the shared bundle |
| bus_write | output | 1 | Direction on the shared bundle |
| bus_data | output | DATA_W | Data on the shared bundle |

## Verification
The link is exercised with isolated writes, with writes held back-to-back on `cmd_valid`, and with non-write commands mixed between writes. The isolated writes expose the settle count and the edge order. Back-to-back traffic shows whether a new bundle can appear before the previous four edges finish. The non-write commands tell a handshake that only completes apart from one that also stores data. Each pattern runs once with a slave clock faster than the master clock and once with a much slower one, so that an ordering bug that a lucky clock ratio would hide still shows up.

// File: rtl/hs4_pkg.sv
// Shared types for the four-phase write link.
package hs4_pkg;
    typedef enum logic [1:0] {
        M_IDLE   = 2'd0,
        M_SETTLE = 2'd1,
        M_REQ    = 2'd2,
        M_REL    = 2'd3
    } mst_state_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } slv_state_t;
endpackage

// File: rtl/hs4_sync.sv
// Multi-flop synchroniser for one control line.
// Assumes: d is driven from a foreign clock domain and holds each level long
// enough to be seen (guaranteed by the interlocked handshake).
module hs4_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain;

    // Shift the incoming level through N flops of the local clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[N-2:0], d};
    end

    assign q = chain[N-1];
endmodule

// File: rtl/hs4_master.sv
// Master side of the link: accepts a local command, drives the bundle,
// waits the decode settle interval, then runs request through the four edges.
// Assumes: ack_s is already synchronised to clk.
module hs4_master
    import hs4_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int SETTLE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              cmd_ready,
    output logic              cmd_done,
    input  logic              ack_s,
    output logic              req,
    output logic [ADDR_W-1:0] b_addr,
    output logic              b_write,
    output logic [DATA_W-1:0] b_data
);
    localparam int SETTLE_EFF = (SETTLE_CYC < 1) ? 1 : SETTLE_CYC;
    localparam int CNT_W      = $clog2(SETTLE_EFF + 1);

    mst_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic              done_q;

    // Master state machine, settle counter and bundle registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= M_IDLE;
            cnt     <= '0;
            req     <= 1'b0;
            done_q  <= 1'b0;
            b_addr  <= '0;
            b_write <= 1'b0;
            b_data  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                M_IDLE: begin
                    if (cmd_valid) begin
                        b_addr  <= cmd_addr;
                        b_write <= cmd_write;
                        b_data  <= cmd_data;
                        cnt     <= '0;
                        state   <= M_SETTLE;
                    end
                end
                M_SETTLE: begin
                    if (cnt == CNT_W'(SETTLE_EFF - 1)) begin
                        req   <= 1'b1;
                        state <= M_REQ;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                M_REQ: begin
                    if (ack_s) begin
                        req   <= 1'b0;
                        state <= M_REL;
                    end
                end
                M_REL: begin
                    if (!ack_s) begin
                        done_q <= 1'b1;
                        state  <= M_IDLE;
                    end
                end
                default: state <= M_IDLE;
            endcase
        end
    end

    assign cmd_ready = (state == M_IDLE);
    assign cmd_done  = done_q;

    // Checker-only age counter: cycles since the bundle was loaded.
    logic [CNT_W-1:0] chk_age;
    always_ff @(posedge clk) begin
        if (!rst_n)                                chk_age <= '0;
        else if (cmd_ready && cmd_valid)           chk_age <= '0;
        else if (chk_age != CNT_W'(SETTLE_EFF))    chk_age <= chk_age + 1'b1;
    end

    // R3
    settle_before_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> (chk_age == CNT_W'(SETTLE_EFF)));
    // R5
    req_drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(ack_s));
    // R7
    req_rise_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> !$past(ack_s));
    // R2
    bundle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ($stable(b_addr) && $stable(b_data) && $stable(b_write)));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);
endmodule

// File: rtl/hs4_slave.sv
// Slave side of the link: on a synchronised request it stores a write and
// raises acknowledge, then waits for request to fall before releasing it.
// Assumes: req_s is synchronised to clk; the bundle is stable while request
// is high at the master.
module hs4_slave
    import hs4_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_s,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_write,
    input  logic [DATA_W-1:0] b_data,
    output logic              ack,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    slv_state_t state;

    // Slave state machine, write strobe and captured bundle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            ack     <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (req_s) begin
                        if (b_write) begin
                            wr_en   <= 1'b1;
                            wr_addr <= b_addr;
                            wr_data <= b_data;
                        end
                        ack   <= 1'b1;
                        state <= S_ACK;
                    end
                end
                S_ACK: begin
                    if (!req_s) begin
                        ack   <= 1'b0;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R4
    wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    // R4
    wr_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $rose(ack));
    // R6
    ack_drop_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> !$past(req_s));
    // R4
    ack_rise_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req_s));
endmodule

// File: rtl/hs4_link.sv
// Top of the four-phase write link: master and slave in separate clock
// domains joined by request/acknowledge through synchronisers.
// Assumes: m_clk and s_clk are unrelated; each reset is synchronous to its
// own clock.
module hs4_link #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int SETTLE_CYC  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              m_clk,
    input  logic              m_rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              cmd_ready,
    output logic              cmd_done,
    input  logic              s_clk,
    input  logic              s_rst_n,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              bus_req,
    output logic              bus_ack,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_data
);
    logic ack_in_m;
    logic req_in_s;

    hs4_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
        .clk(m_clk), .rst_n(m_rst_n), .d(bus_ack), .q(ack_in_m)
    );

    hs4_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
        .clk(s_clk), .rst_n(s_rst_n), .d(bus_req), .q(req_in_s)
    );

    hs4_master #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)
    ) master_i (
        .clk(m_clk), .rst_n(m_rst_n),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .cmd_done(cmd_done),
        .ack_s(ack_in_m), .req(bus_req),
        .b_addr(bus_addr), .b_write(bus_write), .b_data(bus_data)
    );

    hs4_slave #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) slave_i (
        .clk(s_clk), .rst_n(s_rst_n), .req_s(req_in_s),
        .b_addr(bus_addr), .b_write(bus_write), .b_data(bus_data),
        .ack(bus_ack), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // R7
    busy_not_ready_chk: assert property (@(posedge m_clk) disable iff (!m_rst_n)
        bus_req |-> !cmd_ready);
endmodule

// File: tb/hs4_link_tb.sv
// Scoreboard bench for hs4_link: a driver queues expected writes, monitors
// compare slave writes and check handshake ordering at both clocks.
module hs4_link_tb_top;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SETTLE = 3;

    logic m_clk = 1'b0;
    logic s_clk = 1'b0;
    logic m_rst_n = 1'b0;
    logic s_rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic cmd_ready, cmd_done, wr_en, bus_req, bus_ack, bus_write;
    logic [AW-1:0] wr_addr, bus_addr;
    logic [DW-1:0] wr_data, bus_data;

    int checks = 0;
    int fails = 0;
    int s_half = 7;
    int writes_seen = 0;
    int dones_seen = 0;
    int cmds_sent = 0;
    int writes_sent = 0;
    logic [AW+DW-1:0] exp_q[$];

    always #10 m_clk = ~m_clk;
    always #(s_half) s_clk = ~s_clk;

    hs4_link #(.ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(SETTLE), .SYNC_STAGES(2)) dut_i (
        .m_clk(m_clk), .m_rst_n(m_rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_ready(cmd_ready), .cmd_done(cmd_done),
        .s_clk(s_clk), .s_rst_n(s_rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_data(bus_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Driver: present one command, wait for acceptance, push expectation.
    task automatic send(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_data = d;
        while (!cmd_ready) @(negedge m_clk);
        if (w) begin exp_q.push_back({a, d}); writes_sent++; end
        cmds_sent++;
        @(negedge m_clk);
    endtask

    task automatic idle();
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (cmds_sent != dones_seen) @(negedge m_clk);
        repeat (4) @(negedge m_clk);
    endtask

    // Master-side monitor: settle timing, bundle content and edge ordering.
    logic prev_req = 1'b0, prev_ack = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_data = '0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_data = '0;
    logic acc_w = 1'b0;
    int age = -1;
    always @(negedge m_clk) begin
        if (m_rst_n) begin
            if (age >= 0) age++;
            if (age == 1) begin
                // R2: bundle presented, request still low
                check(bus_addr == acc_addr && bus_data == acc_data && bus_write == acc_w
                      && !bus_req, "R2", "bundle after accept",
                      {bus_addr, bus_data}, {acc_addr, acc_data});
            end
            if (bus_req && !prev_req) begin
                // R3: request after exactly SETTLE cycles
                check(age == SETTLE + 1, "R3", "settle interval", age, SETTLE + 1);
                age = -1;
            end
            if (!bus_req && prev_req)
                check(prev_ack, "R5", "req fell without ack", prev_ack, 1);
            if (!bus_ack && prev_ack)
                check(!prev_req, "R6", "ack fell with req high", prev_req, 0);
            if (prev_req && bus_req)
                check(bus_addr == prev_addr && bus_data == prev_data, "R2",
                      "bundle changed under req", bus_addr, prev_addr);
            if (bus_req || bus_ack)
                if (cmd_ready) check(1'b0, "R7", "ready while busy", cmd_ready, 0);
            if (cmd_done) dones_seen++;
            if (cmd_valid && cmd_ready) begin
                age = 0; acc_addr = cmd_addr; acc_data = cmd_data; acc_w = cmd_write;
            end
            prev_req = bus_req; prev_ack = bus_ack;
            prev_addr = bus_addr; prev_data = bus_data;
        end
    end

    // Slave-side monitor: pop and compare every write strobe.
    logic prev_wr = 1'b0;
    always @(negedge s_clk) begin
        if (s_rst_n) begin
            if (wr_en) begin
                logic [AW+DW-1:0] e;
                writes_seen++;
                check(!prev_wr, "R4", "strobe wider than one cycle", prev_wr, 0);
                check(bus_ack, "R4", "ack with strobe", bus_ack, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected write", wr_addr, 0);
                end else begin
                    e = exp_q.pop_front();
                    check({wr_addr, wr_data} == e, "R4", "write content",
                          {wr_addr, wr_data}, e);
                end
            end
            prev_wr = wr_en;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge m_clk);
        fails++; checks++;
        $display("FAIL watchdog: actual=hang expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic traffic(input logic [7:0] seed);
        logic [AW-1:0] held_a;
        logic [DW-1:0] held_d;
        // isolated writes
        for (int i = 0; i < 3; i++) begin
            send(1'b1, {seed, 8'(i)}, {seed, 24'(i * 7919 + 5)});
            idle();
            drain();
        end
        // back-to-back writes held on cmd_valid (R7 ordering)
        for (int i = 0; i < 4; i++) send(1'b1, {seed, 8'(16 + i)}, 32'hA5A50000 + i);
        idle();
        drain();
        // R7: all done pulses arrived, in-order pops already compared
        check(dones_seen == cmds_sent, "R7", "done count", dones_seen, cmds_sent);
        // R8: non-write leaves the slave storage outputs unchanged
        held_a = wr_addr; held_d = wr_data;
        send(1'b0, 16'hDEAD, 32'hBAD0BAD0);
        idle();
        drain();
        check(wr_addr == held_a && wr_data == held_d, "R8", "non-write changed storage",
              {wr_addr, wr_data}, {held_a, held_d});
        check(dones_seen == cmds_sent, "R8", "non-write completed", dones_seen, cmds_sent);
        // mixed back-to-back
        send(1'b1, {seed, 8'hE0}, 32'h01234567);
        send(1'b0, {seed, 8'hE1}, 32'hFFFFFFFF);
        send(1'b1, {seed, 8'hE2}, 32'h89ABCDEF);
        idle();
        drain();
        // R9: every queued write delivered at this clock ratio
        check(exp_q.size() == 0 && writes_seen == writes_sent, "R9", "writes delivered",
              writes_seen, writes_sent);
    endtask

    initial begin
        repeat (5) @(negedge m_clk);
        // R1: reset state
        check(cmd_ready && !bus_req && !bus_ack && !wr_en && !cmd_done, "R1",
              "state in reset", {cmd_ready, bus_req, bus_ack, wr_en, cmd_done}, 5'b10000);
        m_rst_n = 1'b1; s_rst_n = 1'b1;
        repeat (3) @(negedge m_clk);
        check(cmd_ready && !bus_req && !bus_ack && !wr_en && !cmd_done, "R1",
              "state after reset", {cmd_ready, bus_req, bus_ack, wr_en, cmd_done}, 5'b10000);
        // slave faster than master
        traffic(8'h11);
        // slave much slower than master (R9)
        s_half = 47;
        repeat (20) @(negedge m_clk);
        traffic(8'h22);
        check(fails == 0, "R9", "no earlier failures", fails, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule